// File: doc/BRIEF.md
# Pin change interrupt monitor

This unit watches a small group of general-purpose input pins and records level changes on them. For each pin, software chooses whether a low-to-high transition, a high-to-low transition, or both should be recorded. A recorded transition sets a sticky per-pin flag. The flags are combined into one pending bit, which drives an interrupt request and a wake request once a master enable is set. Transitions are still detected and flagged while the master enable is off. The master enable only gates the two request outputs.

Software reaches the unit through a simple register port: a 2-bit select, a write strobe, write data, and combinational read data. The port holds four registers: the rising-enable mask, the falling-enable mask, the flag register and a control word. Flags can only be cleared by writes, never set. A transition that lands in the same cycle as a flag write is kept, so a read-modify-write that clears only known bits never loses an event. The pins are asynchronous and pass through a two-flop synchroniser before a one-cycle history comparison.

Top module: `ioc_monitor`

## Requirements
- R1: With bit i of the rising mask set, a 0-to-1 change on pin i sets flag i. The flag can be read after the third rising clock edge, counting the edge that first samples the new pin level.
- R2: With bit i of the falling mask set, a 1-to-0 change on pin i sets flag i, with the same latency as R1.
- R3: With both mask bits set for a pin, a change in either direction sets its flag.
- R4: A flag stays set until software writes a 0 to it. A change whose direction is not enabled leaves the flag unchanged.
- R5: The pending output is high exactly when at least one flag is set.
- R6: The irq output equals master enable AND pending. Changes are still detected and flagged while master enable is 0.
- R7: While master enable is 1, wake goes high in the clock cycle in which an enabled change is detected. This is one cycle before the flag can be read, so the flag is already latched for any access made after wake-up.
- R8: Reset (rst_n low for at least 3 cycles) clears both masks, the flags and master enable. A pin held steady through reset produces no flag after release.
- R9: If an enabled change is detected on pin i in the cycle of a flag-register write, flag i ends up set whatever value was written to it.
- R10: A flag write updates each flag to (written bit AND current flag) OR new change. Writing a 1 never sets a clear flag.
- R11: reg_sel encoding: 0 selects the rising mask, 1 the falling mask, 2 the flags and 3 the control word. Control bit 0 is the master enable, and all other control bits read 0. A write takes effect at the clock edge that samples reg_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | PINS | Asynchronous pin levels |
| reg_sel | input | 2 | Register select (R11 encoding) |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | PINS | Write data |
| reg_rdata | output | PINS | Read data of the selected register |
| pending | output | 1 | OR of all flags |
| irq | output | 1 | Gated interrupt request |
| wake | output | 1 | Wake request for low-power mode |

## Verification
On every cycle, the embedded properties check three flag rules: flags are sticky between writes, a change detected during a flag write survives the write, and a written 1 never raises a flag. They also check that a detected change with master enable set leads to pending on the next cycle. The bench's reference model compares all outputs and the selected read data on every clock, and directed scenarios cover the remaining behaviour. These scenarios cover direction filtering, either-edge pins, detection with the master enable off, the one-cycle lead of wake over the readable flag, the exact write/edge collision cycle, and quiet release from reset with pins held high.

// File: rtl/ioc_pkg.sv
// Shared definitions for the pin change monitor.
// Assumes: the register port select is exactly two bits wide.
package ioc_pkg;
    typedef enum logic [1:0] {
        SEL_RISE = 2'd0,
        SEL_FALL = 2'd1,
        SEL_FLAG = 2'd2,
        SEL_CTRL = 2'd3
    } ioc_sel_e;

    localparam int SYNC_DEPTH = 2;
    localparam int CTRL_MIE_BIT = 0;
endpackage

// File: rtl/ioc_pin_sync.sv
// Multi-stage synchroniser for asynchronous pin levels.
// Assumes: each pin is an independent level signal, so per-bit
// synchronisation is enough. The stages are not reset on purpose, so
// they keep tracking the pins while reset is held.
module ioc_pin_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] pin_async,
    output logic [WIDTH-1:0] pin_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Capture the raw pins in the first stage.
    always_ff @(posedge clk) begin
        stage_q[0] <= pin_async;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Shift each later stage from its predecessor.
            always_ff @(posedge clk) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign pin_sync = stage_q[STAGES-1];
endmodule

// File: rtl/ioc_edge_find.sv
// Compares the synchronised pins against last cycle's value and reports
// enabled transitions per pin.
// Assumes: the history register reloads from the synchronised value every
// cycle, including during reset, so it holds the pin state at release.
module ioc_edge_find #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] pin_sync,
    input  logic [WIDTH-1:0] rise_mask,
    input  logic [WIDTH-1:0] fall_mask,
    output logic [WIDTH-1:0] hits
);
    logic [WIDTH-1:0] hist_q;

    // Remember the previous synchronised level of every pin.
    always_ff @(posedge clk) begin
        hist_q <= pin_sync;
    end

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            logic went_up, went_down;
            assign went_up   = pin_sync[i] & ~hist_q[i];
            assign went_down = ~pin_sync[i] & hist_q[i];
            assign hits[i]   = (rise_mask[i] & went_up) | (fall_mask[i] & went_down);
        end
    endgenerate
endmodule

// File: rtl/ioc_flag_bank.sv
// Sticky per-pin flags. A detected transition always sets its flag. A
// software write can only clear bits, and a transition detected in the
// cycle of that write still sets its flag.
// Assumes: hits is zero while reset is asserted, because the masks are reset.
module ioc_flag_bank #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] hits,
    input  logic             wr_flags,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] flags_q
);
    // Merge new transitions into the flags and apply clear-only writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else if (wr_flags)
            flags_q <= (wr_data & flags_q) | hits;
        else
            flags_q <= flags_q | hits;
    end

    // R4
    flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_flags |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R9
    edge_beats_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_flags |=> ((flags_q & $past(hits)) == $past(hits)));

    // R10
    write_never_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_flags |=> ((flags_q & ~$past(flags_q) & ~$past(hits)) == '0));
endmodule

// File: rtl/ioc_monitor.sv
// Top of the pin change monitor. It holds the mask and control registers,
// the read mux and the request outputs, and it chains
// synchroniser -> edge finder -> flag bank.
// Assumes: reset is held for at least SYNC_DEPTH+1 cycles with the pins steady.
module ioc_monitor #(
    parameter int PINS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_in,
    input  logic [1:0]      reg_sel,
    input  logic            reg_wr,
    input  logic [PINS-1:0] reg_wdata,
    output logic [PINS-1:0] reg_rdata,
    output logic            pending,
    output logic            irq,
    output logic            wake
);
    import ioc_pkg::*;

    logic [PINS-1:0] pin_sync, hits, flags;
    logic [PINS-1:0] rise_q, fall_q;
    logic            mie_q;
    ioc_sel_e        sel;

    assign sel = ioc_sel_e'(reg_sel);

    ioc_pin_sync #(.WIDTH(PINS), .STAGES(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .pin_async(pin_in),
        .pin_sync (pin_sync)
    );

    ioc_edge_find #(.WIDTH(PINS)) u_edge (
        .clk      (clk),
        .pin_sync (pin_sync),
        .rise_mask(rise_q),
        .fall_mask(fall_q),
        .hits     (hits)
    );

    ioc_flag_bank #(.WIDTH(PINS)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .hits    (hits),
        .wr_flags(reg_wr && sel == SEL_FLAG),
        .wr_data (reg_wdata),
        .flags_q (flags)
    );

    // Software-written masks and the master enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_q <= '0;
            fall_q <= '0;
            mie_q  <= 1'b0;
        end else if (reg_wr) begin
            case (sel)
                SEL_RISE: rise_q <= reg_wdata;
                SEL_FALL: fall_q <= reg_wdata;
                SEL_CTRL: mie_q  <= reg_wdata[CTRL_MIE_BIT];
                default:  ;
            endcase
        end
    end

    // Read mux for the selected register.
    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_RISE: reg_rdata = rise_q;
            SEL_FALL: reg_rdata = fall_q;
            SEL_FLAG: reg_rdata = flags;
            SEL_CTRL: reg_rdata[CTRL_MIE_BIT] = mie_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign pending = |flags;
    assign irq     = mie_q & pending;
    // Wake looks at the detection itself, one cycle ahead of the flag.
    assign wake    = mie_q & (pending | (|hits));

    // R7
    wake_then_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mie_q && (|hits)) |=> pending);

    // R6
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != '0));
endmodule

// File: tb/ioc_monitor_test.sv
module ioc_monitor_test;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] pin_in = '0;
    logic [1:0]   reg_sel = 2'd0;
    logic         reg_wr = 1'b0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic pending, irq, wake;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    ioc_monitor #(.PINS(N)) uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_sel(reg_sel),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pending(pending), .irq(irq), .wake(wake)
    );

    always #4 clk = ~clk;

    // Behavioural reference state.
    logic [N-1:0] m_rise = '0, m_fall = '0, m_flag = '0, m_sync = '0, m_prev = '0;
    logic         m_mie = 1'b0;
    logic [N-1:0] delay_q[$] = '{'0};

    function automatic logic [N-1:0] m_hits();
        logic [N-1:0] h = '0;
        for (int i = 0; i < N; i++) begin
            if (m_rise[i] && m_sync[i] && !m_prev[i]) h[i] = 1'b1;
            if (m_fall[i] && !m_sync[i] && m_prev[i]) h[i] = 1'b1;
        end
        return h;
    endfunction

    task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Advance the reference model at each rising edge.
    always @(posedge clk) begin
        logic [N-1:0] h;
        h = m_hits();
        cyc++;
        if (!rst_n) begin
            m_rise = '0; m_fall = '0; m_flag = '0; m_mie = 1'b0;
        end else begin
            if (reg_wr && reg_sel == 2'd2) m_flag = (reg_wdata & m_flag) | h;
            else m_flag = m_flag | h;
            if (reg_wr && reg_sel == 2'd0) m_rise = reg_wdata;
            if (reg_wr && reg_sel == 2'd1) m_fall = reg_wdata;
            if (reg_wr && reg_sel == 2'd3) m_mie = reg_wdata[0];
        end
        m_prev = m_sync;
        m_sync = delay_q.pop_front();
        delay_q.push_back(pin_in);
    end

    // Compare every output against the model between edges.
    always @(negedge clk) begin
        if (cyc > 2 && !done) begin
            logic [N-1:0] exp_rd;
            logic exp_pend;
            exp_pend = |m_flag;
            case (reg_sel)
                2'd0: exp_rd = m_rise;
                2'd1: exp_rd = m_fall;
                2'd2: exp_rd = m_flag;
                default: exp_rd = {{(N-1){1'b0}}, m_mie};
            endcase
            chk(reg_sel == 2'd2 ? "R4 flags" : "R11 readback", reg_rdata, exp_rd);
            chk("R5 pending", {{(N-1){1'b0}}, pending}, {{(N-1){1'b0}}, exp_pend});
            chk("R6 irq", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, m_mie & exp_pend});
            chk("R7 wake", {{(N-1){1'b0}}, wake},
                {{(N-1){1'b0}}, m_mie & (exp_pend | (|m_hits()))});
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_reg(logic [1:0] s, logic [N-1:0] d);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        step(1);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [1:0] s, logic [N-1:0] exp);
        reg_sel = s;
        @(negedge clk);
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        pin_in = 4'b0101;                       // steady high pins through reset
        step(5);
        rst_n = 1'b1;
        step(4);
        rd_chk("R8 flags after reset", 2'd2, 4'b0000);
        rd_chk("R8 rise mask after reset", 2'd0, 4'b0000);
        rd_chk("R8 ctrl after reset", 2'd3, 4'b0000);

        wr_reg(2'd0, 4'b0001);
        wr_reg(2'd1, 4'b0010);
        rd_chk("R11 rise mask", 2'd0, 4'b0001);
        rd_chk("R11 fall mask", 2'd1, 4'b0010);

        pin_in = 4'b0000; step(4);              // falls on pins 0 and 2, not enabled
        rd_chk("R4 disabled direction ignored", 2'd2, 4'b0000);

        pin_in = 4'b0001; step(2);              // pin0 rises, master enable off
        rd_chk("R1 not yet readable", 2'd2, 4'b0000);
        step(1);
        rd_chk("R1 rise flagged", 2'd2, 4'b0001);
        chk("R6 irq gated off", {3'b0, irq}, 4'b0000);
        chk("R5 pending set", {3'b0, pending}, 4'b0001);

        pin_in = 4'b0011; step(4);              // pin1 rises, only fall enabled
        rd_chk("R2 rise on fall-only pin", 2'd2, 4'b0001);
        pin_in = 4'b0001; step(4);
        rd_chk("R2 fall flagged", 2'd2, 4'b0011);

        wr_reg(2'd0, 4'b1001);
        wr_reg(2'd1, 4'b1010);
        pin_in = 4'b1001; step(4);
        rd_chk("R3 rise on both-edge pin", 2'd2, 4'b1011);
        wr_reg(2'd2, 4'b0111);
        rd_chk("R4 write zero clears", 2'd2, 4'b0011);
        pin_in = 4'b0001; step(4);
        rd_chk("R3 fall on both-edge pin", 2'd2, 4'b1011);

        wr_reg(2'd2, 4'b0000);
        rd_chk("R4 clear all", 2'd2, 4'b0000);
        wr_reg(2'd2, 4'b1111);
        rd_chk("R10 writing ones sets nothing", 2'd2, 4'b0000);
        chk("R5 pending clear", {3'b0, pending}, 4'b0000);

        wr_reg(2'd3, 4'b0001);
        rd_chk("R11 ctrl readback", 2'd3, 4'b0001);
        pin_in = 4'b0011; step(4);              // pin1 rises: not enabled
        reg_sel = 2'd2;
        pin_in = 4'b0001; step(2);              // pin1 falls: now in detection
        @(negedge clk); #1;
        chk("R7 wake leads flag", {3'b0, wake}, 4'b0001);
        chk("R7 flag not yet set", reg_rdata, 4'b0000);
        step(1);
        rd_chk("R7 flag latched after wake", 2'd2, 4'b0010);
        chk("R6 irq raised", {3'b0, irq}, 4'b0001);

        pin_in = 4'b1001; step(2);              // pin3 rise detected next edge
        wr_reg(2'd2, 4'b0000);                  // write lands on the detection edge
        rd_chk("R9 edge wins over write", 2'd2, 4'b1000);

        step(3);
        finish_run();
    end
endmodule